// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits on the master side of an I2C bus and frees the bus when a target device keeps SDA low. This happens when the master was reset partway through a transfer and the target's state machine is still waiting for more clocks. The block watches the synchronized bus lines. It starts when software requests it, or automatically when SDA is low while SCL is high and the bus should be idle. It then keeps its own SDA driver released and clocks SCL to move the target's state machine forward. When the burst is over it forms a STOP condition, and it reports done or fail depending on whether SDA is high at the end.

The outputs are drive-low enables, so the pads act as open-drain. A programmable divider sets the length of each SCL half-period in system clocks. The burst length is fixed at nine pulses. This covers both a stuck read, where the target frees SDA at its acknowledge slot, and a stuck write, where the target only frees SDA after the ninth clock. The burst is never cut short.

Top module: `i2c_recovery`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sclDrvLow`, `sdaDrvLow`, `busy`, `done` and `fail` are all 0.
- R2: `sclIn` and `sdaIn` pass through a two-stage synchronizer. If `sdaIn` falls between two clock edges, an automatic start shows on `busy` and `sclDrvLow` only after the third following rising edge, and not before.
- R3: In idle with `autoEn` = 1, a synchronized SDA low while synchronized SCL is high starts recovery. With `autoEn` = 0, a held-low SDA starts nothing.
- R4: A `startReq` sampled in idle while the synchronized SDA is high sends no clocks. It raises `done` for one cycle, starting on the same edge, and `busy` stays 0.
- R5: A recovery sends exactly 9 SCL pulses with `sdaDrvLow` = 0. Each low phase of SCL lasts exactly H system clocks, and `sclDrvLow` or `sdaDrvLow` is 1 only while `busy` is 1.
- R6: All 9 pulses are sent even when the target lets SDA go high after an earlier pulse.
- R7: After the ninth pulse the STOP is made as follows:
  - SCL is pulled low.
  - `sdaDrvLow` rises exactly one cycle later, while SCL is still low.
  - SCL is released after H cycles.
  - `sdaDrvLow` falls H cycles after that, with SCL released.
- R8: H cycles after SDA is released, the block returns to idle and raises exactly one of `done` (synchronized SDA high) or `fail` (SDA still low) for one cycle.
- R9: H is `divHalf`, raised to 4 when it is smaller. It is captured when recovery starts, and later changes to `divHalf` do not affect a recovery in progress.
- R10: `startReq` has no effect while `busy` is 1. A recovery gives exactly one completion, and no second run follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request a recovery attempt (sampled in idle) |
| autoEn | input | 1 | Allow automatic start on a stuck-low SDA |
| divHalf | input | DIV_W | System clocks per SCL half-period |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Recovery sequence in progress |
| done | output | 1 | One-cycle pulse: bus ended free |
| fail | output | 1 | One-cycle pulse: SDA still low after STOP |

## Verification
Each result has a fixed cycle in which it is due:
- An automatic start shows on `busy` after the third edge following the SDA fall.
- An immediate `done` appears after the edge that samples `startReq`.
- Every SCL low phase lasts H samples.
- `sdaDrvLow` rises on the second sample of the STOP low phase.
- `done` or `fail` appears exactly H samples after the SDA release.

The bench samples on falling clock edges. Each time a flag appears, a monitor pops the expected record and compares the pulse counts, phase widths, STOP ordering and release-to-flag gap. Targets that free SDA after one pulse, after nine pulses, or never are each exercised.

// File: rtl/i2c_rec_pkg.sv
package i2c_rec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BURST_LO,
    ST_BURST_HI,
    ST_STOP_LO,
    ST_STOP_HI,
    ST_STOP_REL
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchDiv;
    logic loadTimer;
    logic clrPulse;
    logic countPulse;
    logic sclLow;
    logic sclRel;
    logic sdaLow;
    logic sdaRel;
    logic setDone;
    logic setFail;
  } recStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic sdaHigh;
    logic sclHigh;
    logic halfDone;
    logic lastPulse;
  } recStatus_t;

endpackage

// File: rtl/i2c_rec_sync.sv
module i2c_rec_sync #(
  parameter int    STAGES  = 2,
  parameter logic  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic dIn,
  output logic dOut
);

  logic [STAGES-1:0] stage;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign dOut = stage[STAGES-1];

endmodule

// File: rtl/i2c_rec_datapath.sv
module i2c_rec_datapath
  import i2c_rec_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int PULSES      = 9,
  parameter int MIN_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  recStrobe_t       strb,
  output recStatus_t       stat,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             done,
  output logic             fail
);

  localparam int CNT_W = $clog2(PULSES + 1);
  localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(MIN_HALF);
  localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(PULSES - 1);

  logic             sclSync;
  logic             sdaSync;
  logic [DIV_W-1:0] effHalf;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] loadVal;
  logic [DIV_W-1:0] halfCnt;
  logic [CNT_W-1:0] pulseCnt;

  i2c_rec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclSync (
    .clk(clk), .rst(rst), .dIn(sclIn), .dOut(sclSync)
  );

  i2c_rec_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rst(rst), .dIn(sdaIn), .dOut(sdaSync)
  );

  // clamp tiny divider values so the synchronizer can settle inside a phase
  assign effHalf = (divHalf < HALF_FLOOR) ? HALF_FLOOR : divHalf;
  assign loadVal = strb.latchDiv ? effHalf : divReg;

  always_ff @(posedge clk) begin
    if (rst)               divReg <= HALF_FLOOR;
    else if (strb.latchDiv) divReg <= effHalf;
  end

  // half-period timer: reaches zero on the last cycle of a phase
  always_ff @(posedge clk) begin
    if (rst)                   halfCnt <= '0;
    else if (strb.loadTimer)   halfCnt <= loadVal - 1'b1;
    else if (halfCnt != '0)    halfCnt <= halfCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  pulseCnt <= '0;
    else if (strb.clrPulse)   pulseCnt <= '0;
    else if (strb.countPulse) pulseCnt <= pulseCnt + 1'b1;
  end

  // line drive enables
  always_ff @(posedge clk) begin
    if (rst)              sclDrvLow <= 1'b0;
    else if (strb.sclLow) sclDrvLow <= 1'b1;
    else if (strb.sclRel) sclDrvLow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)              sdaDrvLow <= 1'b0;
    else if (strb.sdaLow) sdaDrvLow <= 1'b1;
    else if (strb.sdaRel) sdaDrvLow <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      fail <= 1'b0;
    end else begin
      done <= strb.setDone;
      fail <= strb.setFail;
    end
  end

  assign stat.sdaHigh   = sdaSync;
  assign stat.sclHigh   = sclSync;
  assign stat.halfDone  = (halfCnt == '0);
  assign stat.lastPulse = (pulseCnt == LAST_IDX);

endmodule

// File: rtl/i2c_rec_ctrl.sv
module i2c_rec_ctrl
  import i2c_rec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       autoEn,
  input  recStatus_t stat,
  output recStrobe_t strb,
  output logic       busy
);

  recState_t state;
  recState_t nextState;
  logic      stuckSeen;

  assign stuckSeen = !stat.sdaHigh && (startReq || (autoEn && stat.sclHigh));

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (stuckSeen) begin
          nextState      = ST_BURST_LO;
          strb.latchDiv  = 1'b1;
          strb.loadTimer = 1'b1;
          strb.clrPulse  = 1'b1;
          strb.sclLow    = 1'b1;
        end else if (startReq) begin
          strb.setDone = 1'b1;
        end
      end
      ST_BURST_LO: begin
        if (stat.halfDone) begin
          nextState      = ST_BURST_HI;
          strb.sclRel    = 1'b1;
          strb.loadTimer = 1'b1;
        end
      end
      ST_BURST_HI: begin
        if (stat.halfDone) begin
          strb.sclLow    = 1'b1;
          strb.loadTimer = 1'b1;
          if (stat.lastPulse) begin
            nextState = ST_STOP_LO;
          end else begin
            nextState       = ST_BURST_LO;
            strb.countPulse = 1'b1;
          end
        end
      end
      ST_STOP_LO: begin
        // SDA pulled low one cycle after SCL went low
        strb.sdaLow = 1'b1;
        if (stat.halfDone) begin
          nextState      = ST_STOP_HI;
          strb.sclRel    = 1'b1;
          strb.loadTimer = 1'b1;
        end
      end
      ST_STOP_HI: begin
        if (stat.halfDone) begin
          nextState      = ST_STOP_REL;
          strb.sdaRel    = 1'b1;
          strb.loadTimer = 1'b1;
        end
      end
      ST_STOP_REL: begin
        if (stat.halfDone) begin
          nextState = ST_IDLE;
          if (stat.sdaHigh) strb.setDone = 1'b1;
          else              strb.setFail = 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2c_recovery.sv
module i2c_recovery
  import i2c_rec_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int PULSES      = 9,
  parameter int MIN_HALF    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startReq,
  input  logic             autoEn,
  input  logic [DIV_W-1:0] divHalf,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             busy,
  output logic             done,
  output logic             fail
);

  recStrobe_t strb;
  recStatus_t stat;

  i2c_rec_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startReq (startReq),
    .autoEn   (autoEn),
    .stat     (stat),
    .strb     (strb),
    .busy     (busy)
  );

  i2c_rec_datapath #(
    .DIV_W       (DIV_W),
    .PULSES      (PULSES),
    .MIN_HALF    (MIN_HALF),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .divHalf   (divHalf),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .stat      (stat),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .done      (done),
    .fail      (fail)
  );

endmodule

// File: rtl/i2c_recovery_chk.sv
module i2c_recovery_chk #(
  parameter int PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic sclDrvLow,
  input logic sdaDrvLow,
  input logic busy,
  input logic done,
  input logic fail
);

  localparam int EDGE_W = $clog2(PULSES + 2) + 1;

  logic              rstQ;
  logic              sclPrev;
  logic [EDGE_W-1:0] lowEdges;

  always_ff @(posedge clk) begin
    rstQ <= rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclPrev  <= 1'b0;
      lowEdges <= '0;
    end else begin
      sclPrev <= sclDrvLow;
      if (!busy)                      lowEdges <= '0;
      else if (sclDrvLow && !sclPrev) lowEdges <= lowEdges + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (rstQ) begin
      assert_reset_state_R1: assert (!sclDrvLow && !sdaDrvLow && !busy && !done && !fail)
        else $error("outputs not cleared by reset");
    end
  end

  assert_release_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sclDrvLow && !sdaDrvLow));

  // burst pulses plus the STOP clock, regardless of when SDA came free
  assert_full_burst_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (lowEdges == EDGE_W'(PULSES + 1)));

  assert_sda_after_scl_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(sdaDrvLow) |-> (sclDrvLow && $past(sclDrvLow)));

  assert_sda_release_scl_high_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sdaDrvLow) |-> (!sclDrvLow && $past(!sclDrvLow)));

  assert_flag_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  assert_fail_single_R8: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

endmodule

bind i2c_recovery i2c_recovery_chk #(.PULSES(PULSES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sclDrvLow (sclDrvLow),
  .sdaDrvLow (sdaDrvLow),
  .busy      (busy),
  .done      (done),
  .fail      (fail)
);

// File: tb/sim_i2c_recovery.sv
`timescale 1ns/1ps
module sim_i2c_recovery;

  localparam int DIV_W = 16;

  typedef struct {
    int isFail;
    int pulses;
    int stops;
    int gap;
    int lowOk;
    int orderOk;
  } result_t;

  logic             clk = 1'b0;
  logic             rst;
  logic             startReq;
  logic             autoEn;
  logic [DIV_W-1:0] divHalf;
  logic             sclIn, sdaIn;
  logic             sclDrvLow, sdaDrvLow, busy, done, fail;

  // target model
  logic holdReq;
  int   relAfter;
  int   risesSeen;
  logic tgtHold;

  int nChecks = 0;
  int nFails  = 0;
  int finishCount = 0;
  int expH = 4;
  result_t expQ[$];

  // monitor accumulators
  int pulses, stops, gap, lowRun;
  int lowOk, orderOk, gapRun;
  logic prevScl, prevSda;

  always #2.5 clk = ~clk;

  assign tgtHold = holdReq && (relAfter == 0 || risesSeen < relAfter);
  assign sclIn   = !sclDrvLow;
  assign sdaIn   = !(sdaDrvLow || tgtHold);

  i2c_recovery #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst(rst), .startReq(startReq), .autoEn(autoEn),
    .divHalf(divHalf), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearAcc();
    pulses = 0; stops = 0; gap = 0; lowRun = 0;
    lowOk = 1; orderOk = 1; gapRun = 0;
  endtask

  // monitor: scoreboard side
  always @(negedge clk) begin
    if (rst) begin
      clearAcc();
      prevScl = 1'b0;
      prevSda = 1'b0;
      risesSeen = 0;
    end else begin
      if (done || fail) begin
        if (expQ.size() == 0) begin
          chk("R10", "unexpected completion", 1, 0);
        end else begin
          result_t e;
          e = expQ.pop_front();
          chk("R8", "fail flag", int'(fail), e.isFail);
          chk("R5", "released-SDA pulses", pulses, e.pulses);
          chk("R7", "STOP clocks", stops, e.stops);
          chk("R8", "release-to-flag gap", gap, e.gap);
          chk("R9", "low phase width ok", lowOk, e.lowOk);
          chk("R7", "STOP ordering ok", orderOk, e.orderOk);
        end
        clearAcc();
        finishCount++;
      end else if (gapRun != 0) begin
        gap++;
      end
      if (!holdReq) risesSeen = 0;
      if (sclDrvLow) begin
        lowRun = prevScl ? lowRun + 1 : 1;
      end else if (prevScl) begin
        if (lowRun != expH) lowOk = 0;
        if (sdaDrvLow) stops++;
        else           pulses++;
        if (holdReq)   risesSeen++;
      end
      if (sdaDrvLow && !prevSda) begin
        if (!(sclDrvLow && lowRun == 2)) orderOk = 0;
      end
      if (!sdaDrvLow && prevSda) begin
        if (sclDrvLow) orderOk = 0;
        gapRun = 1;
        gap = 1;
      end
      prevScl = sclDrvLow;
      prevSda = sdaDrvLow;
    end
  end

  task automatic tick();
    @(negedge clk);
    #0.2;
  endtask

  task automatic waitFinish();
    int s;
    s = finishCount;
    while (finishCount == s) tick();
  endtask

  task automatic pushExp(input int isFail, input int h);
    result_t e;
    e.isFail = isFail; e.pulses = 9; e.stops = 1; e.gap = h;
    e.lowOk = 1; e.orderOk = 1;
    expQ.push_back(e);
  endtask

  task automatic runRec(input int half, input int rel, input int expFail);
    divHalf = DIV_W'(half);
    expH = (half < 4) ? 4 : half;
    pushExp(expFail, expH);
    relAfter = rel;
    holdReq = 1'b1;
    repeat (3) tick();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    waitFinish();
    holdReq = 1'b0;
    repeat (4) tick();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #500000;
    nFails++;
    $display("FAIL R5 watchdog: actual hung expected completion");
    report();
  end

  initial begin
    rst = 1'b1; startReq = 1'b0; autoEn = 1'b0; divHalf = 4;
    holdReq = 1'b0; relAfter = 0;
    repeat (4) tick();
    // R1: reset state
    chk("R1", "sclDrvLow in reset", int'(sclDrvLow), 0);
    chk("R1", "sdaDrvLow in reset", int'(sdaDrvLow), 0);
    chk("R1", "busy/done/fail in reset", int'({busy, done, fail}), 0);
    rst = 1'b0;
    tick();
    chk("R1", "outputs after reset", int'({sclDrvLow, sdaDrvLow, busy, done, fail}), 0);
    repeat (3) tick();

    // R4: start with a free bus
    begin
      result_t e;
      e.isFail = 0; e.pulses = 0; e.stops = 0; e.gap = 0; e.lowOk = 1; e.orderOk = 1;
      expQ.push_back(e);
    end
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    chk("R4", "immediate done", int'(done), 1);
    chk("R4", "busy stays low", int'(busy), 0);
    chk("R4", "no SCL drive", int'(sclDrvLow), 0);
    tick();
    chk("R4", "done is one cycle", int'(done), 0);
    repeat (3) tick();

    // R3 negative: auto disabled
    holdReq = 1'b1; relAfter = 0;
    repeat (20) tick();
    chk("R3", "no start with autoEn low", int'(busy), 0);
    chk("R3", "no SCL drive with autoEn low", int'(sclDrvLow), 0);
    holdReq = 1'b0;
    repeat (4) tick();

    // R2/R3: automatic start latency
    autoEn = 1'b1; divHalf = 4; expH = 4;
    pushExp(0, 4);
    relAfter = 3;
    holdReq = 1'b1;
    tick();
    chk("R2", "busy after 1 edge", int'(busy), 0);
    tick();
    chk("R2", "busy after 2 edges", int'(busy), 0);
    tick();
    chk("R3", "busy after 3 edges", int'(busy), 1);
    chk("R3", "SCL driven after 3 edges", int'(sclDrvLow), 1);
    waitFinish();
    holdReq = 1'b0;
    autoEn = 1'b0;
    repeat (4) tick();

    // R6: target frees SDA after the first pulse
    runRec(5, 1, 0);
    // R8: target frees SDA only at the ninth pulse (write case)
    runRec(7, 9, 0);
    // R8: target never frees SDA
    divHalf = 4; expH = 4;
    pushExp(1, 4);
    relAfter = 0; holdReq = 1'b1;
    repeat (3) tick();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    waitFinish();
    tick();
    chk("R8", "fail is one cycle", int'(fail), 0);
    chk("R8", "back to idle after fail", int'(busy), 0);
    holdReq = 1'b0;
    repeat (4) tick();

    // R9: divider clamp
    runRec(1, 2, 0);

    // R9: divider captured at start
    divHalf = 6; expH = 6;
    pushExp(0, 6);
    relAfter = 4; holdReq = 1'b1;
    repeat (3) tick();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    repeat (10) tick();
    divHalf = 2;
    waitFinish();
    holdReq = 1'b0;
    divHalf = 4;
    repeat (4) tick();

    // R10: start request while busy
    divHalf = 4; expH = 4;
    pushExp(0, 4);
    relAfter = 2; holdReq = 1'b1;
    repeat (3) tick();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    repeat (12) tick();
    startReq = 1'b1;
    tick();
    startReq = 1'b0;
    waitFinish();
    holdReq = 1'b0;
    repeat (20) tick();
    chk("R10", "no second run", int'(busy), 0);
    chk("R10", "expected queue drained", expQ.size(), 0);

    report();
  end

endmodule